// File: doc/BRIEF.md
# Network Interface Interrupt Aggregator

This block collects the event indications of a network interface's transmit, receive and management engines into one status word and drives a single level-sensitive interrupt line. Each event sets a sticky bit that stays set until software reads the status word. That read returns the bits and clears them in the same access. A 32-bit mask register holds software's choice of which events may raise the interrupt. A set mask bit blocks its event.

The management engine keeps its own 16-bit event word here. It supplies the mask for that word from its own register space. Any unmasked management event forms a summary bit at position 23 of the main status. This bit is computed live, so a main status read never clears it. Only the management engine's own status read, signalled to this block by a pulse, clears the underlying events. A reset-control register lets software request a transmit-side or receive-side reset. Each request stays pending until the matching engine reports that it is done.

Accesses are whole 32-bit words on a simple request bus. Read data is registered and appears one cycle after the request. Two extra offsets reach the status and mask registers, so that older software using shifted addresses keeps working.

Top module: `nic_irq_hub`

## Requirements
- R1: Byte offsets decode as follows: 0x000 is reset control, 0x100 is status and 0x104 is mask. 0x108 behaves exactly as 0x100 and 0x10C exactly as 0x104. A read of any other offset returns zero. Read data appears on `bus_rdata` in the cycle after the request and holds until the next read.
- R2: A write to reset control with bit 0 set raises `tx_rst_req`, and with bit 1 set raises `rx_rst_req`. A raised request stays high until its done input pulses. Writing 0 to a bit does not clear it, and when a write and a done pulse arrive together the write wins. A read returns the pending bits in bits 1:0 and zero above.
- R3: Each event pulse sets its status bit at the next clock edge: receive delivery sets bit 16, no receive descriptor sets bit 17, transmit descriptor consumed sets bit 24 and transmit drained sets bit 25.
- R4: A read of status returns the stored event bits with bit 23 equal to the management summary, and it clears bits 16, 17, 24 and 25. Bit 23 survives the read. Writes to the status offsets have no effect.
- R5: An event that arrives in the same cycle as a clearing status read is kept, and the next status read returns it.
- R6: Each set bit of `mgmt_ev` sets the matching bit of `mgmt_stat`. A `mgmt_rd` pulse clears the whole word, but an event bit arriving in the same cycle remains set.
- R7: The management summary is 1 when `mgmt_stat & ~mgmt_mask` is non-zero. Bit 23 of the main mask has no effect on it.
- R8: `irq` is a register. In the cycle after an edge where status bits other than 23 are set with a clear mask bit, or where the summary is 1, it reads 1; otherwise it reads 0.
- R9: The mask register reads 0xFF7FFFFF after reset and stores all 32 written bits.
- R10: After reset, `irq`, both reset requests, `mgmt_stat`, the stored status and `bus_rdata` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Register access request, one word |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Byte offset of the word |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, registered |
| ev_rx_host | input | 1 | Received frame handed to host |
| ev_rx_nodesc | input | 1 | No receive descriptor available |
| ev_tx_desc | input | 1 | Transmit descriptor consumed |
| ev_tx_idle | input | 1 | Transmit path drained |
| tx_rst_done | input | 1 | Transmit-side reset finished |
| rx_rst_done | input | 1 | Receive-side reset finished |
| tx_rst_req | output | 1 | Transmit-side reset pending |
| rx_rst_req | output | 1 | Receive-side reset pending |
| mgmt_ev | input | MGMT_W | Management event bits |
| mgmt_rd | input | 1 | Management status read, clears the word |
| mgmt_mask | input | MGMT_W | Management mask, a 1 blocks a bit |
| mgmt_stat | output | MGMT_W | Sticky management status word |
| irq | output | 1 | Level-sensitive interrupt |

## Verification
The assertions assume that every input is known after reset. They also assume that a request is either a read or a write, never both, and that `bus_addr` is a byte offset of a whole word. The bench keeps within these limits. It drives inputs only at falling edges and picks addresses only from the five mapped offsets and one unmapped word. It holds `mgmt_mask` at 0xFFFF except where a test opens it on purpose. Event, done and management pulses come in random overlapping mixes. This makes a clearing read, a write to reset control or a management read often coincide with the event it could lose.

// File: rtl/nic_irq_pkg.sv
package nic_irq_pkg;

    // byte offsets on the register bus
    localparam int OFS_RST      = 'h000;
    localparam int OFS_STAT     = 'h100;
    localparam int OFS_MASK     = 'h104;
    localparam int OFS_STAT_ALT = 'h108;
    localparam int OFS_MASK_ALT = 'h10C;

    // status bit positions
    localparam int BIT_RX_HOST   = 16;
    localparam int BIT_RX_NODESC = 17;
    localparam int BIT_MGMT_SUM  = 23;
    localparam int BIT_TX_DESC   = 24;
    localparam int BIT_TX_IDLE   = 25;

    localparam int NUM_EV   = 4;
    localparam int NUM_SIDE = 2;

    // event input k lands on status bit EV_POS[k]
    localparam int EV_POS [NUM_EV] = '{BIT_RX_HOST, BIT_RX_NODESC, BIT_TX_DESC, BIT_TX_IDLE};

    localparam logic [31:0] MASK_RESET = 32'hFF7F_FFFF;

    typedef enum logic [1:0] {
        TGT_NONE,
        TGT_RST,
        TGT_STAT,
        TGT_MASK
    } tgt_e;

endpackage

// File: rtl/nic_irq_decode.sv
module nic_irq_decode
    import nic_irq_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              req_i,
    input  logic [ADDR_W-1:0] addr_i,
    output tgt_e              tgt_o
);

    localparam logic [ADDR_W-1:0] A_RST      = ADDR_W'(OFS_RST);
    localparam logic [ADDR_W-1:0] A_STAT     = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_MASK     = ADDR_W'(OFS_MASK);
    localparam logic [ADDR_W-1:0] A_STAT_ALT = ADDR_W'(OFS_STAT_ALT);
    localparam logic [ADDR_W-1:0] A_MASK_ALT = ADDR_W'(OFS_MASK_ALT);

    always_comb begin
        tgt_o = TGT_NONE;
        if (req_i) begin
            if (addr_i == A_RST) begin
                tgt_o = TGT_RST;
            end else if (addr_i == A_STAT || addr_i == A_STAT_ALT) begin
                tgt_o = TGT_STAT;
            end else if (addr_i == A_MASK || addr_i == A_MASK_ALT) begin
                tgt_o = TGT_MASK;
            end
        end
    end

endmodule

// File: rtl/nic_irq_rstctl.sv
module nic_irq_rstctl #(
    parameter int NUM_SIDE = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                set_en_i,
    input  logic [NUM_SIDE-1:0] set_i,
    input  logic [NUM_SIDE-1:0] done_i,
    output logic [NUM_SIDE-1:0] pend_o
);

    typedef struct packed {
        logic [NUM_SIDE-1:0] pend;
    } rst_state_t;

    rst_state_t          s_d, s_q;
    logic [NUM_SIDE-1:0] pend_nxt;

    for (genvar i = 0; i < NUM_SIDE; i++) begin : g_side
        // a fresh request outranks a completion in the same cycle
        assign pend_nxt[i] = (set_en_i && set_i[i]) ? 1'b1 :
                             (done_i[i] ? 1'b0 : s_q.pend[i]);

        // R2
        side_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (set_en_i && set_i[i]) |=> pend_o[i]);
        // R2
        side_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (done_i[i] && !(set_en_i && set_i[i])) |=> !pend_o[i]);
        // R2
        side_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!done_i[i] && !(set_en_i && set_i[i])) |=> $stable(pend_o[i]));
    end

    always_comb begin
        s_d      = s_q;
        s_d.pend = pend_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pend_o = s_q.pend;

endmodule

// File: rtl/nic_irq_status.sv
module nic_irq_status
    import nic_irq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int MGMT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EV-1:0] ev_i,
    input  logic              rd_clr_i,
    input  logic [MGMT_W-1:0] mgmt_ev_i,
    input  logic              mgmt_clr_i,
    output logic [DATA_W-1:0] stat_o,
    output logic [MGMT_W-1:0] mgmt_o
);

    typedef struct packed {
        logic [DATA_W-1:0] stat;
        logic [MGMT_W-1:0] mgmt;
    } stat_state_t;

    stat_state_t       s_d, s_q;
    logic [DATA_W-1:0] ev_vec;

    always_comb begin
        ev_vec = '0;
        for (int k = 0; k < NUM_EV; k++) begin
            ev_vec[EV_POS[k]] = ev_i[k];
        end
    end

    // clears apply first, then new events are ORed in so none is lost
    always_comb begin
        s_d      = s_q;
        s_d.stat = (rd_clr_i ? '0 : s_q.stat) | ev_vec;
        s_d.mgmt = (mgmt_clr_i ? '0 : s_q.mgmt) | mgmt_ev_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign stat_o = s_q.stat;
    assign mgmt_o = s_q.mgmt;

    for (genvar k = 0; k < NUM_EV; k++) begin : g_ev_chk
        // R3 R5
        ev_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ev_i[k] |=> stat_o[EV_POS[k]]);
    end

    // R4
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr_i && ev_i == '0) |=> (stat_o == '0));

    // R6
    mgmt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mgmt_clr_i && mgmt_ev_i == '0) |=> (mgmt_o == '0));

    // R6
    mgmt_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mgmt_clr_i) |=> ((mgmt_o & $past(mgmt_o)) == $past(mgmt_o)));

endmodule

// File: rtl/nic_irq_combine.sv
module nic_irq_combine #(
    parameter int DATA_W  = 32,
    parameter int MGMT_W  = 16,
    parameter int SUM_BIT = 23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] stat_i,
    input  logic [DATA_W-1:0] mask_i,
    input  logic [MGMT_W-1:0] mgmt_i,
    input  logic [MGMT_W-1:0] mgmt_mask_i,
    output logic              summary_o,
    output logic              irq_o
);

    localparam logic [DATA_W-1:0] SUM_SEL = DATA_W'(1) << SUM_BIT;

    typedef struct packed {
        logic irq;
    } irq_state_t;

    irq_state_t s_d, s_q;
    logic       main_hit;

    always_comb begin
        summary_o = |(mgmt_i & ~mgmt_mask_i);
        // the summary position never goes through the ordinary mask
        main_hit  = |(stat_i & ~mask_i & ~SUM_SEL);
        s_d       = s_q;
        s_d.irq   = main_hit | summary_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign irq_o = s_q.irq;

    // R7
    summary_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mgmt_i & ~mgmt_mask_i) != '0 |=> irq_o);

    // R8
    quiet_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_i & ~mask_i & ~SUM_SEL) == '0 && (mgmt_i & ~mgmt_mask_i) == '0) |=> !irq_o);

    // R8
    main_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_i & ~mask_i & ~SUM_SEL) != '0) |=> irq_o);

endmodule

// File: rtl/nic_irq_hub.sv
module nic_irq_hub
    import nic_irq_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int MGMT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ev_rx_host,
    input  logic              ev_rx_nodesc,
    input  logic              ev_tx_desc,
    input  logic              ev_tx_idle,
    input  logic              tx_rst_done,
    input  logic              rx_rst_done,
    output logic              tx_rst_req,
    output logic              rx_rst_req,
    input  logic [MGMT_W-1:0] mgmt_ev,
    input  logic              mgmt_rd,
    input  logic [MGMT_W-1:0] mgmt_mask,
    output logic [MGMT_W-1:0] mgmt_stat,
    output logic              irq
);

    localparam logic [DATA_W-1:0] SUM_SEL    = DATA_W'(1) << BIT_MGMT_SUM;
    localparam logic [DATA_W-1:0] MASK_INIT  = DATA_W'(MASK_RESET);

    typedef struct packed {
        logic [DATA_W-1:0] mask;
        logic [DATA_W-1:0] rdata;
    } hub_state_t;

    hub_state_t          s_d, s_q;
    tgt_e                tgt;
    logic                rd_en, wr_en;
    logic                rd_stat, wr_rst, wr_mask;
    logic [NUM_SIDE-1:0] pend;
    logic [DATA_W-1:0]   stat;
    logic                summary;
    logic [DATA_W-1:0]   rd_val;

    nic_irq_decode #(
        .ADDR_W (ADDR_W)
    ) u_decode (
        .req_i  (bus_req),
        .addr_i (bus_addr),
        .tgt_o  (tgt)
    );

    assign rd_en   = bus_req && !bus_wr;
    assign wr_en   = bus_req && bus_wr;
    assign rd_stat = rd_en && (tgt == TGT_STAT);
    assign wr_rst  = wr_en && (tgt == TGT_RST);
    assign wr_mask = wr_en && (tgt == TGT_MASK);

    nic_irq_rstctl #(
        .NUM_SIDE (NUM_SIDE)
    ) u_rstctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en_i (wr_rst),
        .set_i    (bus_wdata[NUM_SIDE-1:0]),
        .done_i   ({rx_rst_done, tx_rst_done}),
        .pend_o   (pend)
    );

    nic_irq_status #(
        .DATA_W (DATA_W),
        .MGMT_W (MGMT_W)
    ) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_i       ({ev_tx_idle, ev_tx_desc, ev_rx_nodesc, ev_rx_host}),
        .rd_clr_i   (rd_stat),
        .mgmt_ev_i  (mgmt_ev),
        .mgmt_clr_i (mgmt_rd),
        .stat_o     (stat),
        .mgmt_o     (mgmt_stat)
    );

    nic_irq_combine #(
        .DATA_W  (DATA_W),
        .MGMT_W  (MGMT_W),
        .SUM_BIT (BIT_MGMT_SUM)
    ) u_combine (
        .clk         (clk),
        .rst_n       (rst_n),
        .stat_i      (stat),
        .mask_i      (s_q.mask),
        .mgmt_i      (mgmt_stat),
        .mgmt_mask_i (mgmt_mask),
        .summary_o   (summary),
        .irq_o       (irq)
    );

    always_comb begin
        unique case (tgt)
            TGT_RST:  rd_val = DATA_W'(pend);
            TGT_STAT: rd_val = stat | (summary ? SUM_SEL : '0);
            TGT_MASK: rd_val = s_q.mask;
            default:  rd_val = '0;
        endcase
    end

    always_comb begin
        s_d = s_q;
        if (wr_mask) begin
            s_d.mask = bus_wdata;
        end
        if (rd_en) begin
            s_d.rdata = rd_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.mask  <= MASK_INIT;
            s_q.rdata <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign bus_rdata  = s_q.rdata;
    assign tx_rst_req = pend[0];
    assign rx_rst_req = pend[1];

    // R9
    mask_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mask |=> (s_q.mask == $past(bus_wdata)));

    // R4
    sum_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stat |=> (bus_rdata[BIT_MGMT_SUM] == $past(summary)));

    // R1
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(bus_rdata));

endmodule

// File: tb/nic_irq_hub_bench.sv
module nic_irq_hub_bench;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 12;
    localparam int DATA_W     = 32;
    localparam int MGMT_W     = 16;
    localparam int WD_CYCLES  = 100000;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              bus_req, bus_wr;
    logic [ADDR_W-1:0] bus_addr;
    logic [DATA_W-1:0] bus_wdata, bus_rdata;
    logic              ev_rx_host, ev_rx_nodesc, ev_tx_desc, ev_tx_idle;
    logic              tx_rst_done, rx_rst_done, tx_rst_req, rx_rst_req;
    logic [MGMT_W-1:0] mgmt_ev, mgmt_mask, mgmt_stat;
    logic              mgmt_rd, irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    nic_irq_hub #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .MGMT_W (MGMT_W)
    ) u_nic_irq_hub (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_req      (bus_req),
        .bus_wr       (bus_wr),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .ev_rx_host   (ev_rx_host),
        .ev_rx_nodesc (ev_rx_nodesc),
        .ev_tx_desc   (ev_tx_desc),
        .ev_tx_idle   (ev_tx_idle),
        .tx_rst_done  (tx_rst_done),
        .rx_rst_done  (rx_rst_done),
        .tx_rst_req   (tx_rst_req),
        .rx_rst_req   (rx_rst_req),
        .mgmt_ev      (mgmt_ev),
        .mgmt_rd      (mgmt_rd),
        .mgmt_mask    (mgmt_mask),
        .mgmt_stat    (mgmt_stat),
        .irq          (irq)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h time=%0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference, advanced at every rising edge
    logic [31:0] m_stat, m_mask, m_rdata;
    logic [15:0] m_mgmt;
    logic [1:0]  m_pend;
    logic        m_irq;

    always @(posedge clk) begin
        logic        sum;
        logic [31:0] unmasked;
        if (!rst_n) begin
            m_stat = 0; m_mask = 32'hFF7F_FFFF; m_rdata = 0;
            m_mgmt = 0; m_pend = 0; m_irq = 0;
        end else begin
            sum = ((m_mgmt & ~mgmt_mask) != 0);
            unmasked = m_stat & ~m_mask;
            unmasked[23] = 1'b0;
            m_irq = (unmasked != 0) || sum;
            if (bus_req && !bus_wr) begin
                case (bus_addr)
                    12'h000:          m_rdata = {30'd0, m_pend};
                    12'h100, 12'h108: m_rdata = m_stat | (sum ? 32'h0080_0000 : 32'h0);
                    12'h104, 12'h10C: m_rdata = m_mask;
                    default:          m_rdata = 0;
                endcase
                if (bus_addr == 12'h100 || bus_addr == 12'h108) m_stat = 0;
            end
            if (bus_req && bus_wr && (bus_addr == 12'h104 || bus_addr == 12'h10C))
                m_mask = bus_wdata;
            if (tx_rst_done) m_pend[0] = 1'b0;
            if (rx_rst_done) m_pend[1] = 1'b0;
            if (bus_req && bus_wr && bus_addr == 12'h000) m_pend = m_pend | bus_wdata[1:0];
            if (ev_rx_host)   m_stat[16] = 1'b1;
            if (ev_rx_nodesc) m_stat[17] = 1'b1;
            if (ev_tx_desc)   m_stat[24] = 1'b1;
            if (ev_tx_idle)   m_stat[25] = 1'b1;
            if (mgmt_rd) m_mgmt = 0;
            m_mgmt = m_mgmt | mgmt_ev;
        end
    end

    task automatic idle();
        bus_req = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
        ev_rx_host = 0; ev_rx_nodesc = 0; ev_tx_desc = 0; ev_tx_idle = 0;
        tx_rst_done = 0; rx_rst_done = 0; mgmt_ev = 0; mgmt_rd = 0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        if (rst_n) begin
            chk("R8 irq vs model", {31'd0, irq}, {31'd0, m_irq});
            chk("R2 tx_rst_req vs model", {31'd0, tx_rst_req}, {31'd0, m_pend[0]});
            chk("R2 rx_rst_req vs model", {31'd0, rx_rst_req}, {31'd0, m_pend[1]});
            chk("R6 mgmt_stat vs model", {16'd0, mgmt_stat}, {16'd0, m_mgmt});
            chk("R1 bus_rdata vs model", bus_rdata, m_rdata);
        end
        idle();
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_req = 1; bus_wr = 0; bus_addr = a;
        step();
        d = bus_rdata;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_req = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        step();
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired, all requirements unfinished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [11:0] addrs [6];
        addrs = '{12'h000, 12'h100, 12'h104, 12'h108, 12'h10C, 12'h0F0};
        idle();
        mgmt_mask = 16'hFFFF;
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R10 reset state
        chk("R10 irq after reset", {31'd0, irq}, 0);
        chk("R10 tx_rst_req after reset", {31'd0, tx_rst_req}, 0);
        chk("R10 rx_rst_req after reset", {31'd0, rx_rst_req}, 0);
        chk("R10 mgmt_stat after reset", {16'd0, mgmt_stat}, 0);
        chk("R10 bus_rdata after reset", bus_rdata, 0);
        rd(12'h100, d); chk("R10 status after reset", d, 0);

        // R9 mask reset, R1 aliases and unmapped offset
        rd(12'h104, d); chk("R9 mask reset value", d, 32'hFF7F_FFFF);
        rd(12'h10C, d); chk("R1 mask alias", d, 32'hFF7F_FFFF);
        rd(12'h0F0, d); chk("R1 unmapped reads zero", d, 0);

        // R3 sticky event, R4 clearing read, R8 masked stays low
        ev_rx_host = 1; step();
        step(); chk("R8 masked event keeps irq low", {31'd0, irq}, 0);
        rd(12'h100, d); chk("R3 rx delivery bit 16", d, 32'h0001_0000);
        rd(12'h100, d); chk("R4 status cleared by read", d, 0);

        // R8 timing with open mask
        wr(12'h104, 32'h0); rd(12'h104, d); chk("R9 mask write", d, 0);
        ev_tx_desc = 1; step(); chk("R8 irq not before status", {31'd0, irq}, 0);
        step(); chk("R8 irq one clock after status", {31'd0, irq}, 1);
        rd(12'h108, d); chk("R1 status alias bit 24", d, 32'h0100_0000);
        chk("R8 irq still high at clearing read", {31'd0, irq}, 1);
        step(); chk("R8 irq drops after clear", {31'd0, irq}, 0);

        // R5 event during clearing read
        ev_rx_host = 1; step();
        ev_rx_nodesc = 1; bus_req = 1; bus_wr = 0; bus_addr = 12'h100; step();
        chk("R5 read returns old bits", bus_rdata, 32'h0001_0000);
        rd(12'h100, d); chk("R5 coinciding event kept", d, 32'h0002_0000);

        // R4 writes to status ignored
        ev_tx_idle = 1; step();
        wr(12'h100, 32'h0); wr(12'h108, 32'hFFFF_FFFF);
        rd(12'h100, d); chk("R4 status write ignored", d, 32'h0200_0000);

        // R7 summary, R6 management word
        wr(12'h104, 32'hFFFF_FFFF);
        mgmt_ev = 16'h0004; step();
        chk("R6 mgmt event sticky", {16'd0, mgmt_stat}, 32'h4);
        step(); chk("R7 masked mgmt keeps irq low", {31'd0, irq}, 0);
        rd(12'h100, d); chk("R7 summary zero when masked", d, 0);
        mgmt_mask = 16'hFFFB; step();
        chk("R7 summary raises irq despite mask bit 23", {31'd0, irq}, 1);
        rd(12'h100, d); chk("R7 summary bit 23 read", d, 32'h0080_0000);
        rd(12'h108, d); chk("R4 bit 23 survives read", d, 32'h0080_0000);
        mgmt_rd = 1; step(); chk("R6 mgmt read clears", {16'd0, mgmt_stat}, 0);
        step(); chk("R8 irq low after mgmt clear", {31'd0, irq}, 0);
        mgmt_ev = 16'h0001; mgmt_rd = 1; step();
        chk("R6 event beats mgmt read", {16'd0, mgmt_stat}, 1);
        mgmt_mask = 16'hFFFF; mgmt_rd = 1; step();

        // R2 reset control
        wr(12'h000, 32'h3);
        chk("R2 tx request raised", {31'd0, tx_rst_req}, 1);
        chk("R2 rx request raised", {31'd0, rx_rst_req}, 1);
        wr(12'h000, 32'h0); rd(12'h000, d); chk("R2 zero write keeps requests", d, 32'h3);
        tx_rst_done = 1; step(); chk("R2 tx done clears", {31'd0, tx_rst_req}, 0);
        wr(12'h000, 32'hFFFF_FFFC); rd(12'h000, d); chk("R2 upper bits not stored", d, 32'h2);
        rx_rst_done = 1; bus_req = 1; bus_wr = 1; bus_addr = 12'h000; bus_wdata = 32'h2; step();
        chk("R2 write beats done", {31'd0, rx_rst_req}, 1);
        rx_rst_done = 1; step();

        // mixed traffic against the model
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = $urandom_range(0, 9);
            if (r < 6) begin
                bus_req = 1;
                bus_wr = ($urandom_range(0, 3) == 0);
                bus_addr = addrs[$urandom_range(0, 5)];
                bus_wdata = $urandom();
            end
            ev_rx_host   = ($urandom_range(0, 5) == 0);
            ev_rx_nodesc = ($urandom_range(0, 7) == 0);
            ev_tx_desc   = ($urandom_range(0, 5) == 0);
            ev_tx_idle   = ($urandom_range(0, 7) == 0);
            tx_rst_done  = ($urandom_range(0, 4) == 0);
            rx_rst_done  = ($urandom_range(0, 4) == 0);
            mgmt_ev      = ($urandom_range(0, 5) == 0) ? 16'(1 << $urandom_range(0, 15)) : 16'h0;
            mgmt_rd      = ($urandom_range(0, 5) == 0);
            if ($urandom_range(0, 49) == 0) mgmt_mask = $urandom_range(0, 1) ? 16'hFFFF : 16'($urandom());
            step();
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule